// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a timer peripheral on a shared control bus. A prescaler divides the core clock into ticks, and a single free-running up-counter advances once per tick, wrapping modulo 2^CNT_W. A bank of compare channels watches that counter. Each channel holds a match value, and when the counter steps onto that value the channel sets a sticky status flag. Enabled flags are ORed onto one interrupt line.

One channel, selected by a parameter, can also act as the system watchdog. Software arms the watchdog and enables that channel's interrupt. It takes a snapshot of the counter through the latch register and writes the snapshot plus the timeout into the channel's match register. Moving the match value forward in time is the refresh. If the counter reaches the match value while the watchdog is armed and its interrupt enable is set, the block drives a reset request pulse of fixed length. With either condition missing, no pulse is issued.

The bus is a plain single-cycle register port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`. There is no back-pressure: every access completes in the cycle it is presented. Register map (byte offsets): counter 0x00 (read only); match for channel n at 0x08 + 4·n (NUM_CH at most 6); status 0x20; interrupt enable 0x24; watchdog arm 0x28 bit 0; latch trigger 0x30 (write only); snapshot 0x34 (read only). Unmapped addresses read zero.

Top module: `match_wdt_timer`

## Requirements
- R1: After reset, the counter, the snapshot, every match register, the status register, the interrupt enable register and the arm bit all read 0, and `irq` and `wdt_rst_req` are low.
- R2: The counter increases by one every TICK_DIV clocks, beginning with the TICK_DIV-th edge after reset is released. It wraps from 2^CNT_W−1 to 0.
- R3: Writing a value with bit 0 set to offset 0x30 copies the counter value held before that edge into the snapshot at 0x34. A write to 0x30 with bit 0 clear leaves the snapshot unchanged, and the snapshot holds its value between triggers.
- R4: The match register of channel n at 0x08 + 4·n reads back the low CNT_W bits of the last value written to it.
- R5: Status bit n (offset 0x20) is set on the edge where the counter steps onto channel n's match value. It stays set, and it is also set when the counter wraps onto a small match value.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit has no effect.
- R7: `irq` is high exactly when some status bit is set whose bit in the interrupt enable register (0x24) is also set. A matched channel whose enable bit is clear does not raise `irq`.
- R8: Bit 0 of offset 0x28 arms the watchdog when written 1 and disarms it when written 0, and it reads back as written.
- R9: When the watchdog channel matches while the watchdog is armed and its enable bit is set, `wdt_rst_req` goes high after that same edge and stays high for exactly RST_LEN clocks.
- R10: A watchdog channel match while its interrupt enable bit is clear, or while the watchdog is disarmed, produces no reset request.
- R11: Rewriting the watchdog match value to a later count before the counter reaches the old value prevents any reset at the old value. The reset then occurs at the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | OR of enabled status bits |
| wdt_rst_req | output | 1 | Watchdog reset request pulse |

## Verification
The bench builds the block with CNT_W = 12, TICK_DIV = 2, RST_LEN = 16, six channels and the watchdog on channel 5. A 12-bit counter ticking every second clock wraps after 8192 clocks, so the run can watch the counter step from 4095 to 0 and see a channel match across the wrap. With the short divider, every timeout and refresh race completes in a few dozen cycles. Each expected reset edge is predicted from a bench-side tick model and compared with the observed pulse start and width.

// File: rtl/wdt_timer_pkg.sv
package wdt_timer_pkg;
  localparam logic [7:0] OFS_COUNT  = 8'h00;
  localparam logic [7:0] OFS_MATCH0 = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h20;
  localparam logic [7:0] OFS_IEN    = 8'h24;
  localparam logic [7:0] OFS_ARM    = 8'h28;
  localparam logic [7:0] OFS_LATCH  = 8'h30;
  localparam logic [7:0] OFS_SNAP   = 8'h34;

  function automatic logic [7:0] match_ofs(input int idx);
    return 8'(int'(OFS_MATCH0) + 4 * idx);
  endfunction
endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W    = 32,
  parameter int TICK_DIV = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_req_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o
);
  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] presc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              presc_q <= '0;
        else if (presc_q == LAST) presc_q <= '0;
        else                     presc_q <= presc_q + 1'b1;
      end
      assign tick_o = (presc_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (tick_o) cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          snap_o <= '0;
    else if (snap_req_i) snap_o <= cnt_o;
  end

  // R2: one step per tick, no movement otherwise
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(cnt_o));
  // R3: snapshot only moves on a trigger
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req_i |=> $stable(snap_o));
endmodule

// File: rtl/wdt_compare_bank.sv
module wdt_compare_bank #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [CNT_W-1:0]              wdata_i,
  input  logic [NUM_CH-1:0]             match_we_i,
  input  logic [NUM_CH-1:0]             clr_i,
  output logic [NUM_CH-1:0][CNT_W-1:0]  match_o,
  output logic [NUM_CH-1:0]             status_o,
  output logic [NUM_CH-1:0]             hit_o
);
  logic [CNT_W-1:0] cnt_nxt;
  assign cnt_nxt = cnt_i + 1'b1;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [CNT_W-1:0] match_q;
    logic             stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            match_q <= '0;
      else if (match_we_i[n]) match_q <= wdata_i;
    end

    assign hit_o[n] = tick_i && (cnt_nxt == match_q);

    // a hit on the same edge as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q <= 1'b0;
      else if (hit_o[n]) stat_q <= 1'b1;
      else if (clr_i[n]) stat_q <= 1'b0;
    end

    assign match_o[n]  = match_q;
    assign status_o[n] = stat_q;

    // R5: a hit always leaves the flag set
    p_set_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o[n] |=> status_o[n]);
    // R6: the flag only drops after a clear write
    p_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[n]) |-> $past(clr_i[n]));
  end
endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int LW = $clog2(RST_LEN + 1);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire_i)         left_q <= LW'(RST_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  // R9: a pulse starts only from a fire request
  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire_i));
  generate
    if (RST_LEN >= 2) begin : g_len_chk
      p_pulse_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |=> pulse_o);
    end
  endgenerate
endmodule

// File: rtl/match_wdt_timer.sv
module match_wdt_timer
  import wdt_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_CH   = 6,
  parameter int WDT_CH   = 5,
  parameter int TICK_DIV = 50,
  parameter int RST_LEN  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wdt_rst_req
);
  logic                         wr_en;
  logic                         tick;
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             snap;
  logic [NUM_CH-1:0][CNT_W-1:0] match_w;
  logic [NUM_CH-1:0]            status_w;
  logic [NUM_CH-1:0]            hit_w;
  logic [NUM_CH-1:0]            match_we;
  logic [NUM_CH-1:0]            clr;
  logic [NUM_CH-1:0]            ien_q;
  logic                         arm_q;
  logic                         snap_req;
  logic                         fire;

  assign wr_en    = bus_sel && bus_wr;
  assign snap_req = wr_en && (bus_addr == OFS_LATCH) && bus_wdata[0];
  assign clr      = (wr_en && bus_addr == OFS_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign match_we[n] = wr_en && (bus_addr == match_ofs(n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      arm_q <= 1'b0;
    end else if (wr_en) begin
      if (bus_addr == OFS_IEN) ien_q <= bus_wdata[NUM_CH-1:0];
      if (bus_addr == OFS_ARM) arm_q <= bus_wdata[0];
    end
  end

  wdt_tick_counter #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .snap_req_i (snap_req),
    .tick_o     (tick),
    .cnt_o      (cnt),
    .snap_o     (snap)
  );

  wdt_compare_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .cnt_i      (cnt),
    .wdata_i    (bus_wdata[CNT_W-1:0]),
    .match_we_i (match_we),
    .clr_i      (clr),
    .match_o    (match_w),
    .status_o   (status_w),
    .hit_o      (hit_w)
  );

  assign fire = hit_w[WDT_CH] && arm_q && ien_q[WDT_CH];

  wdt_reset_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire),
    .pulse_o (wdt_rst_req)
  );

  assign irq = |(status_w & ien_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_COUNT:  bus_rdata = 32'(cnt);
      OFS_SNAP:   bus_rdata = 32'(snap);
      OFS_STATUS: bus_rdata = 32'(status_w);
      OFS_IEN:    bus_rdata = 32'(ien_q);
      OFS_ARM:    bus_rdata = 32'(arm_q);
      default:    bus_rdata = '0;
    endcase
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == match_ofs(n)) bus_rdata = 32'(match_w[n]);
    end
  end

  // R10: a reset pulse only begins when armed and enabled
  p_reset_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> $past(arm_q && ien_q[WDT_CH]));
  // R7: interrupt stays low while every enable is clear
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/match_wdt_timer_test.sv
module match_wdt_timer_test;
  localparam int CW = 12, NCH = 6, WCH = 5, DIV = 2, RLEN = 16;
  localparam longint MOD = 64'd1 << CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_rst_req;

  int total = 0, bad = 0;
  longint ecount;
  longint expq[$];
  bit done = 1'b0;
  logic prev_rst = 1'b0;
  int width = 0;
  longint mon_e;

  always #10 clk = ~clk;

  match_wdt_timer #(.CNT_W(CW), .NUM_CH(NCH), .WDT_CH(WCH), .TICK_DIV(DIV), .RST_LEN(RLEN)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_rst_req(wdt_rst_req));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecount <= 0; else ecount <= ecount + 1;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cntx(input longint e);
    return (e / DIV) % MOD;
  endfunction

  function automatic longint nhit(input longint from, input longint m);
    for (longint e = from + 1; e < from + 4 * MOD * DIV; e++)
      if ((e % DIV) == 0 && cntx(e) == m) return e;
    return -1;
  endfunction

  task automatic rd(input logic [7:0] a, output longint d);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 d = longint'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    bus_addr = a; bus_wdata = v; bus_sel = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic upto(input longint e);
    while (ecount < e) @(negedge clk);
  endtask

  task automatic stat_bit(input int n, output longint b);
    longint d;
    rd(8'h20, d);
    b = (d >> n) & 1;
  endtask

  // snapshot driver: latches, checks, returns the captured count
  task automatic take_snap(output longint l);
    longint d;
    wr(8'h30, 32'h1);
    l = cntx(ecount - 1);
    rd(8'h34, d);
    check("R3 snapshot value", d, l);
  endtask

  // monitor: pops expected reset start edges and checks width
  always @(negedge clk) if (rst_n) begin
    if (wdt_rst_req && !prev_rst) begin
      if (expq.size() == 0) check("R10 unexpected reset request edge", ecount, -1);
      else begin
        mon_e = expq.pop_front();
        check("R9 reset start edge", ecount, mon_e);
      end
      width = 1;
    end else if (wdt_rst_req) width++;
    else if (prev_rst) check("R9 reset pulse length", width, RLEN);
    prev_rst = wdt_rst_req;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint d, l, l2, m, m2, h, h1, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); check("R1 counter", d, 0);
    rd(8'h34, d); check("R1 snapshot", d, 0);
    rd(8'h20, d); check("R1 status", d, 0);
    rd(8'h24, d); check("R1 enable", d, 0);
    rd(8'h28, d); check("R1 arm", d, 0);
    for (int n = 0; n < NCH; n++) begin
      rd(8'(8 + 4 * n), d); check("R1 match", d, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 reset req", wdt_rst_req, 0);

    // R2 counting
    repeat (7) @(negedge clk);
    rd(8'h00, d); check("R2 counter step", d, cntx(ecount));
    repeat (10) @(negedge clk);
    rd(8'h00, d); check("R2 counter step", d, cntx(ecount));

    // R4 readback with truncation
    for (int n = 0; n < NCH; n++) begin
      wr(8'(8 + 4 * n), 32'hFFFF_FF00 + 32'(n));
      rd(8'(8 + 4 * n), d); check("R4 match readback", d, 64'hF00 + n);
    end

    // R8 arm readback
    wr(8'h28, 32'h1); rd(8'h28, d); check("R8 arm set", d, 1);
    wr(8'h28, 32'h0); rd(8'h28, d); check("R8 arm clear", d, 0);

    // R3 snapshot capture and hold
    take_snap(l);
    repeat (30) @(negedge clk);
    rd(8'h34, d); check("R3 snapshot holds", d, l);
    wr(8'h30, 32'h2);
    rd(8'h34, d); check("R3 trigger without bit0 ignored", d, l);

    // R5 / R7 enabled channel 2
    wr(8'h24, 32'h04);
    wr(8'h20, 32'h3F);
    take_snap(l);
    m = (l + 10) % MOD;
    wr(8'h10, 32'(m));
    h = nhit(ecount, m);
    upto(h - 1);
    check("R7 irq before match", irq, 0);
    stat_bit(2, b); check("R5 status before match", b, 0);
    upto(h);
    check("R7 irq at match", irq, 1);
    stat_bit(2, b); check("R5 status at match", b, 1);
    repeat (20) @(negedge clk);
    stat_bit(2, b); check("R5 status sticky", b, 1);
    wr(8'h20, 32'h0);
    stat_bit(2, b); check("R6 write 0 keeps status", b, 1);
    check("R6 irq kept", irq, 1);
    wr(8'h20, 32'h04);
    stat_bit(2, b); check("R6 W1C clears status", b, 0);
    check("R6 irq after clear", irq, 0);

    // R7 masked channel 1
    take_snap(l);
    m = (l + 6) % MOD;
    wr(8'h0C, 32'(m));
    h = nhit(ecount, m);
    upto(h + 1);
    stat_bit(1, b); check("R7 masked status set", b, 1);
    check("R7 masked irq low", irq, 0);
    wr(8'h20, 32'h02);

    // R10 armed but enable clear
    wr(8'h28, 32'h1);
    take_snap(l);
    m = (l + 8) % MOD;
    wr(8'h1C, 32'(m));
    h = nhit(ecount, m);
    upto(h + RLEN + 2);
    stat_bit(WCH, b); check("R10 wdt status set", b, 1);
    check("R10 no reset without enable", wdt_rst_req, 0);
    wr(8'h20, 32'h20);

    // R9 full watchdog expiry
    wr(8'h24, 32'h20);
    take_snap(l);
    m = (l + 12) % MOD;
    wr(8'h1C, 32'(m));
    h = nhit(ecount, m);
    expq.push_back(h);
    upto(h - 1); check("R9 reset low before match", wdt_rst_req, 0);
    upto(h);     check("R9 reset high at match", wdt_rst_req, 1);
    upto(h + RLEN - 1); check("R9 reset high last cycle", wdt_rst_req, 1);
    upto(h + RLEN);     check("R9 reset low after pulse", wdt_rst_req, 0);
    check("R9 irq from wdt channel", irq, 1);
    wr(8'h20, 32'h20);

    // R11 refresh before expiry
    take_snap(l);
    m = (l + 20) % MOD;
    wr(8'h1C, 32'(m));
    h1 = nhit(ecount, m);
    upto(h1 - 12);
    take_snap(l2);
    m2 = (l2 + 40) % MOD;
    wr(8'h1C, 32'(m2));
    h = nhit(ecount, m2);
    expq.push_back(h);
    upto(h1 + 2);
    check("R11 no reset at old match", wdt_rst_req, 0);
    upto(h + RLEN + 2);
    check("R11 reset pulse consumed", expq.size(), 0);
    wr(8'h20, 32'h20);

    // R10 disarmed
    wr(8'h28, 32'h0);
    rd(8'h28, d); check("R8 disarm readback", d, 0);
    take_snap(l);
    m = (l + 8) % MOD;
    wr(8'h1C, 32'(m));
    h = nhit(ecount, m);
    upto(h + RLEN + 2);
    check("R10 no reset while disarmed", wdt_rst_req, 0);
    stat_bit(WCH, b); check("R10 disarmed status set", b, 1);

    // R2 / R5 wrap
    wr(8'h24, 32'h01);
    wr(8'h08, 32'd3);
    wr(8'h20, 32'h3F);
    h = nhit(ecount, MOD - 1);
    upto(h);
    rd(8'h00, d); check("R2 counter at top", d, MOD - 1);
    upto(h + DIV);
    rd(8'h00, d); check("R2 counter wraps to 0", d, 0);
    h = nhit(ecount, 3);
    upto(h - 1); check("R5 irq before wrapped match", irq, 0);
    upto(h);     check("R5 irq at wrapped match", irq, 1);

    repeat (4) @(negedge clk);
    check("R9 all expected resets seen", expq.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule